// File: doc/BRIEF.md
# Disk Sector Data Field Write Framer

This block produces the byte stream for one sector's data field as it is laid down on a disk surface. A start pulse begins a frame. The frame opens with a run of zero bytes that lets the read channel lock, then carries a sync byte of 0xA1 written with a missing clock, then a data mark of 0xF8, then the user data, then a 16-bit check code, and it closes with a short run of zero bytes. The user data is pulled from a ready/valid source. Its length is a sector-size value counted in blocks of `BLK_LEN` bytes.

The downstream serializer reads the current byte, its missing-clock flag and the write-gate level. It pulses `take_i` once it has consumed the byte, and the block then presents the next byte. A data byte is pulled from the source only in the cycle the serializer takes the byte before it. If the source has no byte ready at that moment, the frame still runs to its end with a zero byte in that slot, and the completion status reports an over-run.

Top module: `wf_frame_writer`

## Requirements
- R1: While reset is held, and while idle after reset, `gate_o`, `mark_o`, `done_o` and `in_ready_o` are 0 and `byte_o` is 0x00.
- R2: One cycle after `start_i` is sampled while idle, `gate_o` is 1 and the frame begins with `PRE_LEN` (default 12) bytes of 0x00, each with `mark_o`=0.
- R3: The byte after the preamble is 0xA1, and it is the only byte of the frame presented with `mark_o`=1.
- R4: The byte after 0xA1 is the data mark 0xF8.
- R5: The data run holds `size_i`*`BLK_LEN` bytes, with `size_i` latched at start. A `size_i` of 0 gives one block.
- R6: Two check bytes follow the data, high byte first. They hold the CRC-16 with polynomial 0x1021, preset to 0xFFFF at start, shifted in MSB first over the 0xA1 byte, the 0xF8 byte and the data bytes as sent.
- R7: `POST_LEN` (default 4) bytes of 0x00 follow the check bytes. When the last of them is taken, `gate_o` falls and `done_o` pulses for one cycle. In the same cycle `status_o` shows 0xFF if no over-run happened in the frame.
- R8: An over-run is a cycle in which `in_ready_o`=1 and `in_valid_i`=0. After an over-run, the byte sent in that data slot is 0x00 and the frame continues. At the end of the frame `status_o` shows 0x06. A new start clears the condition.
- R9: While `gate_o`=1, `byte_o` and `mark_o` change only on a cycle with `take_i`=1. `in_ready_o` is 1 only when `take_i`=1 and the next byte is a data byte.
- R10: `start_i` has no effect while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a frame (sampled while idle) |
| size_i | input | SIZE_W | Data length in blocks of BLK_LEN bytes; 0 means one block |
| in_data_i | input | 8 | User data byte from source |
| in_valid_i | input | 1 | Source byte available |
| in_ready_o | output | 1 | Source byte consumed this cycle |
| byte_o | output | 8 | Current byte for the serializer |
| mark_o | output | 1 | Current byte is written with a missing clock |
| gate_o | output | 1 | Write gate |
| take_i | input | 1 | Serializer consumed the current byte |
| done_o | output | 1 | One-cycle pulse at frame end |
| status_o | output | 8 | Completion code: 0xFF ok, 0x06 over-run |

## Verification
The bench builds the framer with `BLK_LEN`=16 and `SIZE_W`=2, keeping `PRE_LEN`=12 and `POST_LEN`=4. With these values the sizes 0 through 3 cover the zero-means-one rule, a single block, and data runs that cross several block boundaries. Each frame stays under 70 bytes, so one run can exercise every phase, back-to-back and gapped serializer pacing, an over-run in the middle of the data, and a start request arriving mid-frame.

// File: rtl/wf_pkg.sv
package wf_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_SYNC,
    PH_MARK,
    PH_DATA,
    PH_CRC,
    PH_POST
  } wf_phase_e;

  localparam logic [7:0] SYNC_BYTE = 8'hA1;
  localparam logic [7:0] MARK_BYTE = 8'hF8;
  localparam logic [7:0] FILL_BYTE = 8'h00;
endpackage

// File: rtl/wf_seq.sv
module wf_seq import wf_pkg::*; #(
  parameter int unsigned PRE_LEN  = 12,
  parameter int unsigned POST_LEN = 4,
  parameter int unsigned BLK_LEN  = 128,
  parameter int unsigned SIZE_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              take_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              busy_o,
  output logic              adv_o,
  output wf_phase_e         cur_o,
  output wf_phase_e         nxt_o,
  output logic              nxt_first_o
);
  localparam int LEN_W  = $clog2(BLK_LEN) + SIZE_W;
  localparam int PRE_W  = $clog2(PRE_LEN + 1);
  localparam int POST_W = $clog2(POST_LEN + 1);
  localparam int CNT_A  = (LEN_W > PRE_W) ? LEN_W : PRE_W;
  localparam int CNT_W  = (CNT_A > POST_W) ? CNT_A : POST_W;

  wf_phase_e         phase_q, nxt;
  logic [CNT_W-1:0]  cnt_q, nxt_cnt;
  logic [LEN_W-1:0]  len_m1_q, len_d;
  logic [SIZE_W-1:0] blocks;

  assign busy_o = (phase_q != PH_IDLE);
  assign adv_o  = busy_o ? take_i : start_i;
  assign cur_o  = phase_q;
  assign nxt_o  = nxt;
  assign nxt_first_o = (nxt_cnt == '0);

  // zero size means one block
  assign blocks = (size_i == '0) ? SIZE_W'(1) : size_i;
  assign len_d  = LEN_W'(blocks) * LEN_W'(BLK_LEN);

  always_comb begin
    nxt     = phase_q;
    nxt_cnt = cnt_q + CNT_W'(1);
    unique case (phase_q)
      PH_IDLE: begin nxt = PH_PRE; nxt_cnt = '0; end
      PH_PRE:  if (cnt_q == CNT_W'(PRE_LEN - 1)) begin nxt = PH_SYNC; nxt_cnt = '0; end
      PH_SYNC: begin nxt = PH_MARK; nxt_cnt = '0; end
      PH_MARK: begin nxt = PH_DATA; nxt_cnt = '0; end
      PH_DATA: if (cnt_q == CNT_W'(len_m1_q)) begin nxt = PH_CRC; nxt_cnt = '0; end
      PH_CRC:  if (cnt_q == CNT_W'(1)) begin nxt = PH_POST; nxt_cnt = '0; end
      PH_POST: if (cnt_q == CNT_W'(POST_LEN - 1)) begin nxt = PH_IDLE; nxt_cnt = '0; end
      default: begin nxt = PH_IDLE; nxt_cnt = '0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      len_m1_q <= '0;
    end else begin
      if (adv_o) begin
        phase_q <= nxt;
        cnt_q   <= nxt_cnt;
      end
      if (!busy_o && start_i) len_m1_q <= len_d - LEN_W'(1);
    end
  end

  assert_pre_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PRE) |-> (cnt_q < CNT_W'(PRE_LEN)));
  assert_data_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DATA) |-> (cnt_q <= CNT_W'(len_m1_q)));
  assert_len_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(len_m1_q));
endmodule

// File: rtl/wf_crc16.sv
module wf_crc16 #(
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    for (int i = 7; i >= 0; i--) begin
      if (crc_d[15] ^ data_i[i]) crc_d = {crc_d[14:0], 1'b0} ^ POLY;
      else                       crc_d = {crc_d[14:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= 16'hFFFF;
    else if (init_i) crc_q <= 16'hFFFF;
    else if (en_i)   crc_q <= crc_d;
  end

  assign crc_o = crc_q;

  assert_preset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (crc_o == 16'hFFFF));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !en_i) |=> $stable(crc_o));
endmodule

// File: rtl/wf_frame_writer.sv
module wf_frame_writer import wf_pkg::*; #(
  parameter int unsigned PRE_LEN  = 12,
  parameter int unsigned POST_LEN = 4,
  parameter int unsigned BLK_LEN  = 128,
  parameter int unsigned SIZE_W   = 8,
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [7:0]  OK_CODE  = 8'hFF,
  parameter logic [7:0]  OVR_CODE = 8'h06
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [7:0]        in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic [7:0]        byte_o,
  output logic              mark_o,
  output logic              gate_o,
  input  logic              take_i,
  output logic              done_o,
  output logic [7:0]        status_o
);
  logic      busy, adv, nxt_first;
  wf_phase_e cur, nxt;
  logic [15:0] crc;
  logic [7:0]  byte_d, byte_q, status_q;
  logic        mark_d, mark_q, done_q, ovr_q;
  logic        feed_crc, frame_end;

  wf_seq #(
    .PRE_LEN (PRE_LEN),
    .POST_LEN(POST_LEN),
    .BLK_LEN (BLK_LEN),
    .SIZE_W  (SIZE_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .take_i     (take_i),
    .size_i     (size_i),
    .busy_o     (busy),
    .adv_o      (adv),
    .cur_o      (cur),
    .nxt_o      (nxt),
    .nxt_first_o(nxt_first)
  );

  assign in_ready_o = adv && busy && (nxt == PH_DATA);
  assign feed_crc   = adv && (nxt == PH_SYNC || nxt == PH_MARK || nxt == PH_DATA);
  assign frame_end  = adv && (cur == PH_POST) && (nxt == PH_IDLE);

  wf_crc16 #(.POLY(CRC_POLY)) u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .init_i(adv && !busy),
    .en_i  (feed_crc),
    .data_i(byte_d),
    .crc_o (crc)
  );

  always_comb begin
    byte_d = FILL_BYTE;
    mark_d = 1'b0;
    unique case (nxt)
      PH_SYNC: begin byte_d = SYNC_BYTE; mark_d = 1'b1; end
      PH_MARK: byte_d = MARK_BYTE;
      PH_DATA: byte_d = in_valid_i ? in_data_i : FILL_BYTE; // over-run slot sends fill
      PH_CRC:  byte_d = nxt_first ? crc[15:8] : crc[7:0];
      default: byte_d = FILL_BYTE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q   <= FILL_BYTE;
      mark_q   <= 1'b0;
      done_q   <= 1'b0;
      ovr_q    <= 1'b0;
      status_q <= OK_CODE;
    end else begin
      if (adv) begin
        byte_q <= byte_d;
        mark_q <= mark_d;
      end
      done_q <= frame_end;
      if (adv && !busy)                  ovr_q <= 1'b0;
      else if (in_ready_o && !in_valid_i) ovr_q <= 1'b1;
      if (frame_end)
        status_q <= (ovr_q || (in_ready_o && !in_valid_i)) ? OVR_CODE : OK_CODE;
    end
  end

  assign byte_o   = byte_q;
  assign mark_o   = mark_q;
  assign gate_o   = busy;
  assign done_o   = done_q;
  assign status_o = status_q;

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_o |-> (!mark_o && !in_ready_o && byte_o == FILL_BYTE));
  assert_pre_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> (byte_o == FILL_BYTE && !mark_o));
  assert_mark_only_sync_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_o |-> (gate_o && byte_o == SYNC_BYTE));
  assert_mark_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_o && take_i) |=> (byte_o == MARK_BYTE && !mark_o));
  assert_done_on_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_o) |-> done_o);
  assert_overrun_fill_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !in_valid_i) |=> (byte_o == FILL_BYTE));
  assert_hold_no_take_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && !take_i) |=> ($stable(byte_o) && $stable(mark_o)));
  assert_ready_take_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (gate_o && take_i));
  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && start_i && !take_i) |=> (gate_o && $stable(byte_o)));
endmodule

// File: tb/tb_wf_frame_writer.sv
module tb_wf_frame_writer;
  localparam int PRE  = 12;
  localparam int POST = 4;
  localparam int BLK  = 16;
  localparam int SW   = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [SW-1:0] size_i = '0;
  logic [7:0]    in_data_i = 8'h00;
  logic          in_valid_i = 1'b0;
  logic          in_ready_o;
  logic [7:0]    byte_o;
  logic          mark_o, gate_o, take_i = 1'b0, done_o;
  logic [7:0]    status_o;

  wf_frame_writer #(.PRE_LEN(PRE), .POST_LEN(POST), .BLK_LEN(BLK), .SIZE_W(SW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .size_i(size_i),
    .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .byte_o(byte_o), .mark_o(mark_o), .gate_o(gate_o), .take_i(take_i),
    .done_o(done_o), .status_o(status_o)
  );

  always #10 clk_i = ~clk_i;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int frames = 0;
  bit running = 0;

  // scenario controls
  bit req_start = 0;
  int cfg_gap = 1;
  int cfg_drop = -1;
  bit cfg_mid = 0;
  bit mid_done = 0;

  // reference model state
  int m_pos = -1;
  int m_data = 0;
  int m_len = 0;
  int src_k = 0;
  logic [7:0]  m_byte = 8'h00;
  logic        m_mark = 0, m_gate = 0, m_done = 0, m_ovr = 0;
  logic [7:0]  m_status = 8'hFF;
  logic [15:0] m_crc = 16'hFFFF;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] src_val(input int k);
    return 8'((k * 37 + 11) ^ (k >> 2));
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = (r << 1) ^ 16'h1021;
      else              r = r << 1;
    end
    return r;
  endfunction

  function automatic string req_of(input int p);
    if (p < 0) return "R1";
    if (p < PRE) return "R2";
    if (p == PRE) return "R3";
    if (p == PRE + 1) return "R4";
    if (p < PRE + 2 + m_data) return "R5";
    if (p < PRE + 4 + m_data) return "R6";
    return "R7";
  endfunction

  function automatic bit is_data(input int p);
    return (p >= PRE + 2) && (p < PRE + 2 + m_data);
  endfunction

  task automatic load_pos(input bit vl);
    m_mark = 0;
    if (m_pos < PRE) m_byte = 8'h00;
    else if (m_pos == PRE) begin m_byte = 8'hA1; m_mark = 1; m_crc = crc_step(m_crc, m_byte); end
    else if (m_pos == PRE + 1) begin m_byte = 8'hF8; m_crc = crc_step(m_crc, m_byte); end
    else if (is_data(m_pos)) begin
      if (vl) begin m_byte = src_val(src_k); src_k++; end
      else begin m_byte = 8'h00; m_ovr = 1; end
      m_crc = crc_step(m_crc, m_byte);
    end
    else if (m_pos == PRE + 2 + m_data) m_byte = m_crc[15:8];
    else if (m_pos == PRE + 3 + m_data) m_byte = m_crc[7:0];
    else m_byte = 8'h00;
  endtask

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      chk(gate_o === 1'b0 && done_o === 1'b0 && mark_o === 1'b0, "R1 reset gate/done/mark",
          {gate_o, done_o, mark_o}, 0);
      chk(in_ready_o === 1'b0 && byte_o === 8'h00, "R1 reset ready/byte", {in_ready_o, byte_o}, 0);
    end else if (running) begin
      bit tk, st, vl, exp_rdy;
      int np;
      // compare outputs against model
      chk(gate_o === m_gate, {req_of(m_pos), " gate"}, gate_o, m_gate);
      chk(byte_o === m_byte, {req_of(m_pos), " byte"}, byte_o, m_byte);
      chk(mark_o === m_mark, "R3 mark flag", mark_o, m_mark);
      chk(done_o === m_done, "R7 done pulse", done_o, m_done);
      if (m_done) chk(status_o === m_status, m_ovr ? "R8 status" : "R7 status", status_o, m_status);
      // drive inputs for this cycle
      cyc++;
      tk = (cyc % cfg_gap) == 0;
      st = 0;
      if (req_start && m_pos == -1) begin st = 1; req_start = 0; end
      if (cfg_mid && !mid_done && m_pos == 20) begin st = 1; mid_done = 1; end // R10
      np = m_pos + 1;
      exp_rdy = (m_pos >= 0) && tk && is_data(np);
      vl = 1;
      if (cfg_gap > 1 && !tk) vl = 0;
      if (exp_rdy && (np - PRE - 2) == cfg_drop) vl = 0;
      take_i = tk; start_i = st; in_valid_i = vl; in_data_i = src_val(src_k);
      #1;
      chk(in_ready_o === exp_rdy, (exp_rdy && !vl) ? "R8 ready at over-run" : "R9 ready",
          in_ready_o, exp_rdy);
      // advance model
      m_done = 0;
      if (m_pos == -1) begin
        if (st) begin
          m_data = ((size_i == 0) ? 1 : int'(size_i)) * BLK;
          m_len = PRE + 4 + m_data + POST;
          m_crc = 16'hFFFF; m_ovr = 0; m_gate = 1; m_pos = 0;
          load_pos(vl);
        end
      end else if (tk) begin
        if (m_pos == m_len - 1) begin
          m_pos = -1; m_gate = 0; m_byte = 8'h00; m_mark = 0; m_done = 1;
          m_status = m_ovr ? 8'h06 : 8'hFF;
          frames++;
        end else begin
          m_pos++;
          load_pos(vl);
        end
      end
    end
  end

  always @(posedge clk_i) begin
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run_frame(input int sz, input int gap, input int drop, input bit mid);
    int f0 = frames;
    @(posedge clk_i);
    size_i = SW'(sz); cfg_gap = gap; cfg_drop = drop; cfg_mid = mid; mid_done = 0;
    req_start = 1;
    wait (frames == f0 + 1);
    repeat (3) @(posedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);   // R1 reset checks
    #2 rst_ni = 1'b1;
    running = 1;
    repeat (4) @(posedge clk_i);   // R1 idle after reset
    run_frame(1, 1, -1, 0);        // R2..R7 back-to-back
    run_frame(2, 2, -1, 1);        // R9 gapped pacing, R10 mid-frame start
    run_frame(0, 1, -1, 0);        // R5 zero size is one block
    run_frame(3, 1, 5, 0);         // R8 over-run in data slot 5
    run_frame(1, 3, -1, 0);        // R8 cleared by new start
    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule